// File: doc/BRIEF.md
# Banked DRAM Command Spacing Monitor

This block watches the command stream that a controller sends to a banked DRAM device and judges every command against the device's spacing rules. Each cycle it may receive one command, made of a valid strobe, a three-bit operation and a bank number. One cycle later it reports whether that command was legal. An illegal command comes with a code that names the rule it broke. The monitor enforces two kinds of rule at the same time. Per-bank rules cover row cycle, precharge recovery, activate-to-column, open time and read-to-precharge. Device-wide rules cover activate-to-activate, precharge-to-precharge, row-bus packet spacing and column-bus packet spacing.

For each bank, the monitor keeps an open or closed flag and three saturating counters: cycles since the last activate, since the last precharge and since the last read. Four device counters track the last activate, the last precharge, the last row-bus command and the last column-bus command. Only legal commands update this state, so one bad command does not cause false reports later. The monitor also bounds how long a row may stay open. The limit is given in nanoseconds and converted to cycles through a clock-period parameter. A per-bank pulse marks any bank that stays open past it.

Top module: `dram_cmd_timing_chk`

## Requirements
- R1: Operation encoding on `cmd_op`: 0 activate, 1 row precharge, 2 read, 3 write, 4 column precharge; 5 to 7 are reserved and get code 1. A command sampled at a clock edge is reported after the next edge: `rpt_vld` is high, `rpt_bad` is high exactly when `rpt_code` is non-zero, and code 0 means legal. Without a command, `rpt_vld` is low and `rpt_code` is 0.
- R2: An activate to a bank that is already open gets code 2. A read or write to a closed bank gets code 3.
- R3: An activate less than T_RC (28) cycles after the same bank's last accepted activate gets code 4.
- R4: An activate less than T_RP (8) cycles after the same bank's last accepted precharge gets code 5.
- R5: An activate less than T_RR (8) cycles after any accepted activate gets code 6. A row-bus command (activate or row precharge) less than T_PKT (4) cycles after the last accepted row-bus command gets code 12.
- R6: A precharge of either kind to an open bank gets code 7 if it comes less than T_RAS (20) cycles after that bank's activate. It gets code 8 if it comes less than T_RDP (4) cycles after that bank's last accepted read.
- R7: A precharge of either kind less than T_PP (8) cycles after any accepted precharge gets code 9. A precharge to a closed bank is otherwise legal, keeps the bank closed and restarts the precharge spacing.
- R8: A read or write less than T_RCD (7) cycles after its bank's activate gets code 10. A column-bus command (read, write or column precharge) less than T_CC (4) cycles after the last accepted column-bus command gets code 11.
- R9: When a command breaks several rules, the lowest-numbered code is reported.
- R10: A command reported with a non-zero code changes no bank state or counter. A later command is judged as if the bad one never occurred.
- R11: `row_expire[b]` is high for exactly one cycle, in the cycle that follows the edge coming RAS_MAX_CYC = RAS_MAX_NS*1000/CLK_PS cycles (8000 by default) after the edge that accepted bank b's activate, if bank b was not precharged by that edge. A precharge accepted at exactly that gap suppresses the pulse.
- R12: After reset, all banks are closed, no report or expiry is shown, and every interval counts as long enough. Counters saturate and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Operation (encoding in R1) |
| cmd_bank | input | $clog2(NBANK) | Target bank |
| rpt_vld | output | 1 | Verdict for the command of the previous cycle |
| rpt_bad | output | 1 | That command broke a rule |
| rpt_code | output | 4 | Broken rule code, 0 when legal |
| row_expire | output | NBANK | One-cycle pulse per bank held open too long |

## Verification
On every cycle the assertions check the following: report timing; the open-bank and closed-bank state codes; the activate and column spacing against the device counters; that open flags are unchanged after any rejected command; that expiry pulses last one cycle; and that saturated counters only hold or restart. The bench covers the rest through directed sequences compared against a reference model on every clock. These sequences show which code wins when several rules break together, and that exact-boundary gaps are accepted. They also show that rejected commands leave later verdicts untouched, and that the open-time limit fires on a neglected bank but not on one precharged at exactly the limit.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef enum logic [2:0] {
    OP_ACT  = 3'd0,
    OP_PRE  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_CPRE = 3'd4
  } op_e;

  // Lower value wins when several rules break together (R9)
  typedef enum logic [3:0] {
    V_NONE   = 4'd0,
    V_OPCODE = 4'd1,
    V_OPEN   = 4'd2,
    V_CLOSED = 4'd3,
    V_RC     = 4'd4,
    V_RP     = 4'd5,
    V_RR     = 4'd6,
    V_RAS    = 4'd7,
    V_RDP    = 4'd8,
    V_PP     = 4'd9,
    V_RCD    = 4'd10,
    V_CC     = 4'd11,
    V_ROWPKT = 4'd12
  } viol_e;

  function automatic logic op_is_row(input logic [2:0] op);
    return (op == OP_ACT) || (op == OP_PRE);
  endfunction

  function automatic logic op_is_col(input logic [2:0] op);
    return (op == OP_RD) || (op == OP_WR) || (op == OP_CPRE);
  endfunction

  function automatic logic op_is_pre(input logic [2:0] op);
    return (op == OP_PRE) || (op == OP_CPRE);
  endfunction

endpackage

// File: rtl/dtc_sat_cnt.sv
// Cycles-since counter: reset to all ones ("long ago"), restart at 1, saturate.
module dtc_sat_cnt #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '1;
    else if (clr)          cnt <= W'(1);
    else if (cnt != '1)    cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/dtc_bank_slice.sv
module dtc_bank_slice #(
  parameter int CW    = 13,
  parameter int LIMIT = 8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_act,
  input  logic          do_pre,
  input  logic          do_rd,
  output logic          is_open,
  output logic [CW-1:0] since_act,
  output logic [CW-1:0] since_pre,
  output logic [CW-1:0] since_rd,
  output logic          overstay
);

  localparam logic [CW-1:0] EXPIRE_AT = CW'(LIMIT + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      is_open <= 1'b0;
    else if (do_act) is_open <= 1'b1;
    else if (do_pre) is_open <= 1'b0;
  end

  dtc_sat_cnt #(.W(CW)) u_act (.clk(clk), .rst_n(rst_n), .clr(do_act), .cnt(since_act));
  dtc_sat_cnt #(.W(CW)) u_pre (.clk(clk), .rst_n(rst_n), .clr(do_pre), .cnt(since_pre));
  dtc_sat_cnt #(.W(CW)) u_rd  (.clk(clk), .rst_n(rst_n), .clr(do_rd),  .cnt(since_rd));

  assign overstay = is_open && (since_act == EXPIRE_AT);

endmodule

// File: rtl/dtc_rule_eval.sv
module dtc_rule_eval
  import dtc_pkg::*;
#(
  parameter int CW    = 13,
  parameter int T_RC  = 28,
  parameter int T_RAS = 20,
  parameter int T_RP  = 8,
  parameter int T_PP  = 8,
  parameter int T_RR  = 8,
  parameter int T_RCD = 7,
  parameter int T_CC  = 4,
  parameter int T_PKT = 4,
  parameter int T_RDP = 4
) (
  input  logic          vld,
  input  logic [2:0]    op,
  input  logic          is_open,
  input  logic [CW-1:0] since_act,
  input  logic [CW-1:0] since_pre,
  input  logic [CW-1:0] since_rd,
  input  logic [CW-1:0] dev_act,
  input  logic [CW-1:0] dev_pre,
  input  logic [CW-1:0] dev_row,
  input  logic [CW-1:0] dev_col,
  output viol_e         code
);

  function automatic logic too_soon(input logic [CW-1:0] gap, input int lim);
    return int'(gap) < lim;
  endfunction

  always_comb begin
    code = V_NONE;
    if (vld) begin
      if (op == OP_ACT) begin
        if (is_open)                        code = V_OPEN;
        else if (too_soon(since_act, T_RC)) code = V_RC;
        else if (too_soon(since_pre, T_RP)) code = V_RP;
        else if (too_soon(dev_act, T_RR))   code = V_RR;
        else if (too_soon(dev_row, T_PKT))  code = V_ROWPKT;
      end else if (op_is_pre(op)) begin
        if (is_open && too_soon(since_act, T_RAS))       code = V_RAS;
        else if (is_open && too_soon(since_rd, T_RDP))   code = V_RDP;
        else if (too_soon(dev_pre, T_PP))                code = V_PP;
        else if (op == OP_PRE && too_soon(dev_row, T_PKT)) code = V_ROWPKT;
        else if (op == OP_CPRE && too_soon(dev_col, T_CC)) code = V_CC;
      end else if (op == OP_RD || op == OP_WR) begin
        if (!is_open)                        code = V_CLOSED;
        else if (too_soon(since_act, T_RCD)) code = V_RCD;
        else if (too_soon(dev_col, T_CC))    code = V_CC;
      end else begin
        code = V_OPCODE;
      end
    end
  end

endmodule

// File: rtl/dram_cmd_timing_chk.sv
module dram_cmd_timing_chk
  import dtc_pkg::*;
#(
  parameter int NBANK      = 32,
  parameter int T_RC       = 28,
  parameter int T_RAS      = 20,
  parameter int T_RP       = 8,
  parameter int T_PP       = 8,
  parameter int T_RR       = 8,
  parameter int T_RCD      = 7,
  parameter int T_CC       = 4,
  parameter int T_PKT      = 4,
  parameter int T_RDP      = 4,
  parameter int CLK_PS     = 8000,
  parameter int RAS_MAX_NS = 64000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_vld,
  input  logic [2:0]               cmd_op,
  input  logic [$clog2(NBANK)-1:0] cmd_bank,
  output logic                     rpt_vld,
  output logic                     rpt_bad,
  output logic [3:0]               rpt_code,
  output logic [NBANK-1:0]         row_expire
);

  localparam int BW          = $clog2(NBANK);
  localparam int RAS_MAX_CYC = int'((64'(RAS_MAX_NS) * 64'd1000) / 64'(CLK_PS));
  localparam int CW          = $clog2(RAS_MAX_CYC + 3);
  localparam int ND          = 4;
  localparam int D_ACT = 0, D_PRE = 1, D_ROW = 2, D_COL = 3;

  // Per-bank state
  logic [NBANK-1:0] bank_open;
  logic [CW-1:0]    b_sa [NBANK];
  logic [CW-1:0]    b_sp [NBANK];
  logic [CW-1:0]    b_sr [NBANK];

  // Device state
  logic [ND-1:0]    dev_clr;
  logic [CW-1:0]    dev_gap [ND];

  // Named events
  viol_e viol_now;
  logic  cmd_ok, ev_act, ev_pre, ev_rd, ev_row, ev_col;

  dtc_rule_eval #(
    .CW(CW), .T_RC(T_RC), .T_RAS(T_RAS), .T_RP(T_RP), .T_PP(T_PP),
    .T_RR(T_RR), .T_RCD(T_RCD), .T_CC(T_CC), .T_PKT(T_PKT), .T_RDP(T_RDP)
  ) u_eval (
    .vld      (cmd_vld),
    .op       (cmd_op),
    .is_open  (bank_open[cmd_bank]),
    .since_act(b_sa[cmd_bank]),
    .since_pre(b_sp[cmd_bank]),
    .since_rd (b_sr[cmd_bank]),
    .dev_act  (dev_gap[D_ACT]),
    .dev_pre  (dev_gap[D_PRE]),
    .dev_row  (dev_gap[D_ROW]),
    .dev_col  (dev_gap[D_COL]),
    .code     (viol_now)
  );

  // Only accepted commands move the state (R10)
  assign cmd_ok = cmd_vld && (viol_now == V_NONE);
  assign ev_act = cmd_ok && (cmd_op == OP_ACT);
  assign ev_pre = cmd_ok && op_is_pre(cmd_op);
  assign ev_rd  = cmd_ok && (cmd_op == OP_RD);
  assign ev_row = cmd_ok && op_is_row(cmd_op);
  assign ev_col = cmd_ok && op_is_col(cmd_op);

  assign dev_clr[D_ACT] = ev_act;
  assign dev_clr[D_PRE] = ev_pre;
  assign dev_clr[D_ROW] = ev_row;
  assign dev_clr[D_COL] = ev_col;

  for (genvar d = 0; d < ND; d++) begin : g_dev
    dtc_sat_cnt #(.W(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(dev_clr[d]), .cnt(dev_gap[d])
    );
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = (cmd_bank == BW'(b));
    dtc_bank_slice #(.CW(CW), .LIMIT(RAS_MAX_CYC)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_act   (ev_act && hit),
      .do_pre   (ev_pre && hit),
      .do_rd    (ev_rd && hit),
      .is_open  (bank_open[b]),
      .since_act(b_sa[b]),
      .since_pre(b_sp[b]),
      .since_rd (b_sr[b]),
      .overstay (row_expire[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_vld  <= 1'b0;
      rpt_bad  <= 1'b0;
      rpt_code <= 4'd0;
    end else begin
      rpt_vld  <= cmd_vld;
      rpt_bad  <= cmd_vld && (viol_now != V_NONE);
      rpt_code <= viol_now;
    end
  end

endmodule

// File: rtl/dtc_sva.sv
module dtc_sva #(
  parameter int NBANK = 32,
  parameter int CW    = 13,
  parameter int T_RR  = 8,
  parameter int T_CC  = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_vld,
  input logic [2:0]               cmd_op,
  input logic [$clog2(NBANK)-1:0] cmd_bank,
  input logic                     rpt_vld,
  input logic                     rpt_bad,
  input logic [3:0]               rpt_code,
  input logic [NBANK-1:0]         row_expire,
  input logic [NBANK-1:0]         open_vec,
  input logic [CW-1:0]            dev_act_gap,
  input logic [CW-1:0]            dev_col_gap
);

  localparam logic [CW-1:0] CMAX = '1;

  p_rpt_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> rpt_vld);

  p_rpt_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> (!rpt_vld && rpt_code == 4'd0 && !rpt_bad));

  p_act_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == 3'd0 && open_vec[cmd_bank]) |=> (rpt_code == 4'd2));

  p_col_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && (cmd_op == 3'd2 || cmd_op == 3'd3) && !open_vec[cmd_bank])
      |=> (rpt_code == 4'd3));

  p_rr_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == 3'd0 && int'(dev_act_gap) < T_RR) |=> rpt_bad);

  p_cc_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && (cmd_op == 3'd2 || cmd_op == 3'd3 || cmd_op == 3'd4)
     && int'(dev_col_gap) < T_CC) |=> rpt_bad);

  p_no_cascade_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_bad |-> $stable(open_vec));

  p_expire_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|row_expire) |=> ((row_expire & $past(row_expire)) == '0));

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_act_gap == CMAX) |=> (dev_act_gap == CMAX || dev_act_gap == CW'(1)));

endmodule

bind dram_cmd_timing_chk dtc_sva #(
  .NBANK(NBANK), .CW(CW), .T_RR(T_RR), .T_CC(T_CC)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_vld    (cmd_vld),
  .cmd_op     (cmd_op),
  .cmd_bank   (cmd_bank),
  .rpt_vld    (rpt_vld),
  .rpt_bad    (rpt_bad),
  .rpt_code   (rpt_code),
  .row_expire (row_expire),
  .open_vec   (bank_open),
  .dev_act_gap(dev_gap[0]),
  .dev_col_gap(dev_gap[3])
);

// File: tb/dram_cmd_timing_chk_bench.sv
`timescale 1ns/1ps
module dram_cmd_timing_chk_bench;

  localparam int NB   = 32;
  localparam int RMAX = 8000;
  localparam int NEVER = -1000000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_vld = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [4:0]    cmd_bank = 5'd0;
  logic          rpt_vld, rpt_bad;
  logic [3:0]    rpt_code;
  logic [NB-1:0] row_expire;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dram_cmd_timing_chk u_dram_cmd_timing_chk (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .rpt_vld(rpt_vld), .rpt_bad(rpt_bad),
    .rpt_code(rpt_code), .row_expire(row_expire)
  );

  // ---------------- reference model: timestamps, not counters ----------------
  int  cyc;
  bit  m_open [NB];
  int  m_act [NB], m_pre [NB], m_rd [NB];
  int  m_dact, m_dpre, m_drow, m_dcol;
  bit  armed = 0;
  bit            e_vld;
  int            e_code;
  bit [NB-1:0]   e_exp;
  int            exp_cnt [NB];

  function automatic string tag_of(input int c);
    case (c)
      1:       return "R1";
      2, 3:    return "R2";
      4:       return "R3";
      5:       return "R4";
      6, 12:   return "R5";
      7, 8:    return "R6";
      9:       return "R7";
      10, 11:  return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic int judge(input int op, input int b);
    bit [15:0] broke = '0;
    if (op > 4) return 1;
    if (op == 0) begin
      broke[2]  = m_open[b];
      broke[4]  = (cyc - m_act[b]) < 28;
      broke[5]  = (cyc - m_pre[b]) < 8;
      broke[6]  = (cyc - m_dact) < 8;
      broke[12] = (cyc - m_drow) < 4;
    end else if (op == 1 || op == 4) begin
      broke[7]  = m_open[b] && (cyc - m_act[b]) < 20;
      broke[8]  = m_open[b] && (cyc - m_rd[b]) < 4;
      broke[9]  = (cyc - m_dpre) < 8;
      broke[12] = (op == 1) && (cyc - m_drow) < 4;
      broke[11] = (op == 4) && (cyc - m_dcol) < 4;
    end else begin
      broke[3]  = !m_open[b];
      broke[10] = (cyc - m_act[b]) < 7;
      broke[11] = (cyc - m_dcol) < 4;
    end
    for (int i = 0; i < 16; i++) if (broke[i]) return i;  // lowest code wins (R9)
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0;
      for (int b = 0; b < NB; b++) begin
        m_open[b] = 0; m_act[b] = NEVER; m_pre[b] = NEVER; m_rd[b] = NEVER;
      end
      m_dact = NEVER; m_dpre = NEVER; m_drow = NEVER; m_dcol = NEVER;
      e_vld = 0; e_code = 0; e_exp = '0;
    end else begin
      cyc = cyc + 1;
      armed = 1;
      e_vld = cmd_vld;
      e_code = cmd_vld ? judge(int'(cmd_op), int'(cmd_bank)) : 0;
      if (cmd_vld && e_code == 0) begin
        case (int'(cmd_op))
          0: begin m_open[cmd_bank] = 1; m_act[cmd_bank] = cyc; m_dact = cyc; m_drow = cyc; end
          1: begin m_open[cmd_bank] = 0; m_pre[cmd_bank] = cyc; m_dpre = cyc; m_drow = cyc; end
          2: begin m_rd[cmd_bank] = cyc; m_dcol = cyc; end
          3: m_dcol = cyc;
          default: begin m_open[cmd_bank] = 0; m_pre[cmd_bank] = cyc; m_dpre = cyc; m_dcol = cyc; end
        endcase
      end
      for (int b = 0; b < NB; b++)
        e_exp[b] = m_open[b] && (cyc - m_act[b] == RMAX);
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && armed && !done) begin
      n_chk++;
      if (rpt_vld !== e_vld || rpt_code !== 4'(e_code) || rpt_bad !== (e_vld && e_code != 0)) begin
        n_bad++;
        $display("FAIL %s model: vld/bad/code got %0b/%0b/%0d expected %0b/%0b/%0d",
                 tag_of(e_code != 0 ? e_code : int'(rpt_code)), rpt_vld, rpt_bad, rpt_code,
                 e_vld, (e_vld && e_code != 0), e_code);
      end
      n_chk++;
      if (row_expire !== e_exp) begin
        n_bad++;
        $display("FAIL R11 model: row_expire got %h expected %h", row_expire, e_exp);
      end
      for (int b = 0; b < NB; b++) if (row_expire[b]) exp_cnt[b]++;
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic check(input string tag, input int got, input int want, input string what);
    n_chk++;
    if (got != want) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, want);
    end
  endtask

  task automatic issue(input int op, input int bank, input int want, input string tag);
    cmd_vld  = 1'b1;
    cmd_op   = 3'(op);
    cmd_bank = 5'(bank);
    @(negedge clk);
    cmd_vld = 1'b0;
    check(tag, int'(rpt_code), want, $sformatf("op %0d bank %0d code", op, bank));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12", int'(rpt_vld), 0, "rpt_vld in reset");
    check("R12", int'(|row_expire), 0, "row_expire in reset");
    rst_n = 1'b1;
    idle(2);
    check("R12", int'(rpt_vld), 0, "rpt_vld idle after reset");

    issue(2, 0, 3,  "R2");   // read to closed bank
    issue(0, 0, 0,  "R12");  // T: first activate after reset is legal
    idle(2);
    issue(0, 0, 2,  "R2");   // T+3 activate to open bank
    issue(0, 1, 6,  "R5");   // T+4 activate gap 4 device-wide
    issue(2, 0, 10, "R8");   // T+5 read 5 after activate
    issue(3, 0, 10, "R8");   // T+6 write 6 after activate
    issue(2, 0, 0,  "R8");   // T+7 exactly T_RCD
    issue(3, 0, 11, "R8");   // T+8 column gap 1
    idle(2);
    issue(3, 0, 0,  "R8");   // T+11 column gap exactly 4
    issue(1, 0, 7,  "R6");   // T+12 precharge 12 after activate
    idle(6);
    issue(2, 0, 0,  "R8");   // T+19
    issue(1, 0, 8,  "R6");   // T+20 precharge 1 after read
    idle(2);
    issue(1, 0, 0,  "R6");   // T+23 read-to-precharge exactly 4
    idle(1);
    issue(0, 0, 4,  "R3");   // T+25 row cycle 25
    idle(2);
    issue(0, 0, 5,  "R4");   // T+28 precharge recovery 5
    idle(2);
    issue(0, 0, 0,  "R4");   // T+31 recovery exactly 8
    issue(1, 2, 12, "R5");   // T+32 row packet gap 1
    idle(2);
    issue(1, 2, 0,  "R7");   // T+35 precharge of closed bank is legal
    idle(3);
    issue(1, 2, 9,  "R7");   // T+39 precharge gap 4
    issue(0, 3, 0,  "R5");   // T+40
    issue(1, 4, 9,  "R9");   // T+41 PP (9) and row packet (12) both broken
    idle(8);
    issue(2, 0, 0,  "R8");   // T+50
    idle(1);
    issue(4, 0, 8,  "R6");   // T+52 column precharge 2 after read
    idle(1);
    issue(3, 0, 0,  "R10");  // T+54 gap counted from T+50, not rejected T+52
    issue(4, 0, 11, "R8");   // T+55 column precharge shares column spacing
    idle(2);
    issue(4, 0, 0,  "R7");   // T+58 closes bank 0
    issue(2, 0, 3,  "R2");   // T+59 bank 0 closed now
    issue(0, 6, 0,  "R5");   // T+60
    issue(0, 5, 6,  "R5");   // T+61 rejected activate
    idle(7);
    issue(2, 5, 3,  "R10");  // T+69 rejected activate did not open bank 5
    issue(5, 0, 1,  "R1");   // T+70 reserved opcode
    issue(0, 7, 0,  "R11");  // T+71
    idle(RMAX - 1);
    issue(1, 7, 0,  "R11");  // precharge at exactly the open-time limit
    idle(5);
    check("R11", exp_cnt[3], 1, "bank 3 expiry pulses");
    check("R11", exp_cnt[6], 1, "bank 6 expiry pulses");
    check("R11", exp_cnt[7], 0, "bank 7 expiry pulses");
    check("R12", int'(rpt_vld), 0, "rpt_vld idle at end");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule